// File: doc/BRIEF.md
# Multi-Channel Event Fragment Builder

The block assembles one output event fragment per trigger from up to `NCH` input channels. Each channel offers two streams: length entries and data words. Trigger information arrives on its own stream and carries a 32-bit event ID, a 12-bit bunch ID and an 8-bit trigger type. For each fragment the block takes one trigger record and sends an 11-word header. It then visits the enabled channels in ascending order. For each one it reads a length entry, copies that many data words and appends a link word count. It ends the fragment with a 6-word trailer.

All streams use valid/ready. A word moves only in a cycle where valid and ready are both high. While `out_ready` is low the builder holds `out_valid` and `out_data` unchanged. Back-pressure passes straight through to the channel data stream being copied: `dat_ready` of the current channel follows `out_ready`. Four 32-bit configuration inputs supply the constant header fields. In test mode, the event ID in the header comes from an internal fragment counter instead of the trigger record.

Top module: `frag_builder`

## Requirements
- R1: The header has 11 words, sent in this order: 0xB0F00000, 0xEE1234EE, 0x00000009, `cfg_format`, `cfg_module`, `cfg_run`, event ID word, {20'b0, bunch ID}, {24'b0, trigger type}, `cfg_det_type`, {0x80, low 24 bits of the event ID}.
- R2: The trailer has 6 words, sent in this order: {0xF000, count}, status, 0x00000001, {0x0000, count}, 0x00000001, 0xE0F00000.
- R3: A fragment starts only when a trigger record is accepted. `trig_ready` is high only while no fragment is in progress. Channel inputs are not read, and no word is output, before the trigger is accepted.
- R4: The enable mask `chan_en` (bit n = channel n) is latched when the trigger is accepted. A disabled channel never sees `len_ready` or `dat_ready`, and it produces no output words.
- R5: Enabled channels are serviced from lowest to highest index. Each reads one length entry, then copies exactly that many data words unchanged, then emits the link word {12'hC00, 4-bit channel index, 16-bit length}.
- R6: A length entry of zero reads no data words, and the channel still emits its link word with count 0.
- R7: The trailer count (16 bits, in words 0 and 3) equals the number of channel data words in the fragment. It excludes header, trailer and link words.
- R8: The trailer status word is {28'b0, `err_flags`}, sampled while the word is offered. Bit 0 is serial-link parity error, bit 1 is TDC parity error, bit 2 is bunch-ID mismatch, bit 3 is event-ID mismatch.
- R9: With `test_mode` latched at 0, the event ID word is the trigger event ID. With it latched at 1, the event ID word is {8'h00, counter}. In both cases the last header word carries the same 24 low bits.
- R10: The 24-bit fragment counter is 0 after reset. It increments once when the last trailer word is accepted.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` stay unchanged in the next cycle.
- R12: During reset `out_valid`, `len_ready` and `dat_ready` are low. After reset `trig_ready` is high.
- R13: With no channel enabled, the trailer follows the header directly, with a count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| test_mode | input | 1 | Event ID from internal counter, latched per fragment |
| chan_en | input | NCH | Channel enable mask, latched per fragment |
| cfg_format | input | 32 | Header format-version word |
| cfg_module | input | 32 | Header module-ID word |
| cfg_run | input | 32 | Header run-number word |
| cfg_det_type | input | 32 | Header detector-event-type word |
| err_flags | input | 4 | Status flags for the trailer |
| trig_valid | input | 1 | Trigger record valid |
| trig_ready | output | 1 | Trigger record accepted |
| trig_event_id | input | 32 | Trigger event ID |
| trig_bunch_id | input | 12 | Trigger bunch ID |
| trig_type | input | 8 | Trigger type |
| len_valid | input | NCH | Length entry valid, per channel |
| len_ready | output | NCH | Length entry accepted, per channel |
| len_data | input | NCH*16 | Length entries, channel n at bits [16n+15:16n] |
| dat_valid | input | NCH | Data word valid, per channel |
| dat_ready | output | NCH | Data word accepted, per channel |
| dat_word | input | NCH*32 | Data words, channel n at bits [32n+31:32n] |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Output sink ready |
| out_data | output | 32 | Output word |

## Verification
The hardest case to reach from the ports is a fragment that stalls in the middle. Two forms matter: a trigger accepted while the channel streams are still empty, and channel streams already full while no trigger has arrived. The stimulus creates both by delaying one side by many cycles. It checks that nothing leaks out during the gap. Throughout the run, random output back-pressure stalls header, data, link and trailer words. One channel is disabled while its streams hold entries, and the bench confirms those entries are still queued after the fragment.

// File: rtl/frag_pkg.sv
package frag_pkg;
  localparam int WORD_W   = 32;
  localparam int LEN_W    = 16;
  localparam int TID_W    = 24;
  localparam int FLAG_W   = 4;
  localparam int BID_W    = 12;
  localparam int TT_W     = 8;
  localparam int IDX_W    = 4;
  localparam int HDR_LAST = 10;
  localparam int TRL_LAST = 5;

  localparam logic [WORD_W-1:0] K_BOF   = 32'hB0F0_0000;
  localparam logic [WORD_W-1:0] K_MARK  = 32'hEE12_34EE;
  localparam logic [WORD_W-1:0] K_HSIZE = 32'h0000_0009;
  localparam logic [WORD_W-1:0] K_ONE   = 32'h0000_0001;
  localparam logic [WORD_W-1:0] K_EOF   = 32'hE0F0_0000;
  localparam logic [7:0]        K_BOB   = 8'h80;
  localparam logic [15:0]       K_EOB   = 16'hF000;
  localparam logic [11:0]       K_LINK  = 12'hC00;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_LEN, ST_DATA, ST_LINK, ST_TRL
  } fb_state_t;
endpackage

// File: rtl/frag_chan_sel.sv
module frag_chan_sel #(
  parameter int NCH = 8,
  parameter int CHW = 3
) (
  input  logic [NCH-1:0] mask,
  input  logic [CHW-1:0] cur,
  input  logic           from_start,
  output logic           found,
  output logic [CHW-1:0] next
);
  logic [NCH-1:0] elig;

  for (genvar g = 0; g < NCH; g++) begin : g_elig
    assign elig[g] = mask[g] && (from_start || (g > int'(cur)));
  end

  always_comb begin
    found = |elig;
    next  = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (elig[i]) next = CHW'(i);
    end
  end
endmodule

// File: rtl/frag_word_gen.sv
module frag_word_gen
  import frag_pkg::*;
(
  input  logic              in_trailer,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] cfg_format,
  input  logic [WORD_W-1:0] cfg_module,
  input  logic [WORD_W-1:0] cfg_run,
  input  logic [WORD_W-1:0] cfg_det_type,
  input  logic [WORD_W-1:0] evid_word,
  input  logic [TID_W-1:0]  evid_low,
  input  logic [BID_W-1:0]  bunch,
  input  logic [TT_W-1:0]   ttype,
  input  logic [LEN_W-1:0]  total,
  input  logic [FLAG_W-1:0] flags,
  output logic [WORD_W-1:0] word
);
  always_comb begin
    word = '0;
    if (in_trailer) begin
      case (idx)
        4'd0: word = {K_EOB, total};
        4'd1: word = {{(WORD_W-FLAG_W){1'b0}}, flags};
        4'd2: word = K_ONE;
        4'd3: word = {{(WORD_W-LEN_W){1'b0}}, total};
        4'd4: word = K_ONE;
        4'd5: word = K_EOF;
        default: word = '0;
      endcase
    end else begin
      case (idx)
        4'd0:  word = K_BOF;
        4'd1:  word = K_MARK;
        4'd2:  word = K_HSIZE;
        4'd3:  word = cfg_format;
        4'd4:  word = cfg_module;
        4'd5:  word = cfg_run;
        4'd6:  word = evid_word;
        4'd7:  word = {{(WORD_W-BID_W){1'b0}}, bunch};
        4'd8:  word = {{(WORD_W-TT_W){1'b0}}, ttype};
        4'd9:  word = cfg_det_type;
        4'd10: word = {K_BOB, evid_low};
        default: word = '0;
      endcase
    end
  end
endmodule

// File: rtl/frag_builder.sv
module frag_builder
  import frag_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  test_mode,
  input  logic [NCH-1:0]        chan_en,
  input  logic [31:0]           cfg_format,
  input  logic [31:0]           cfg_module,
  input  logic [31:0]           cfg_run,
  input  logic [31:0]           cfg_det_type,
  input  logic [3:0]            err_flags,
  input  logic                  trig_valid,
  output logic                  trig_ready,
  input  logic [31:0]           trig_event_id,
  input  logic [11:0]           trig_bunch_id,
  input  logic [7:0]            trig_type,
  input  logic [NCH-1:0]        len_valid,
  output logic [NCH-1:0]        len_ready,
  input  logic [NCH*16-1:0]     len_data,
  input  logic [NCH-1:0]        dat_valid,
  output logic [NCH-1:0]        dat_ready,
  input  logic [NCH*32-1:0]     dat_word,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [31:0]           out_data
);
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

  fb_state_t          state;
  logic [IDX_W-1:0]   widx;
  logic [CHW-1:0]     cur_ch;
  logic [LEN_W-1:0]   rem;
  logic [LEN_W-1:0]   cur_len;
  logic [LEN_W-1:0]   total;
  logic [NCH-1:0]     mask_q;
  logic               tm_q;
  logic [WORD_W-1:0]  evid_q;
  logic [BID_W-1:0]   bid_q;
  logic [TT_W-1:0]    tt_q;
  logic [TID_W-1:0]   tcnt;

  logic [LEN_W-1:0]   len_arr [NCH];
  logic [WORD_W-1:0]  dat_arr [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_unpack
    assign len_arr[g] = len_data[g*LEN_W +: LEN_W];
    assign dat_arr[g] = dat_word[g*WORD_W +: WORD_W];
  end

  logic           sel_found;
  logic [CHW-1:0] sel_next;

  frag_chan_sel #(.NCH(NCH), .CHW(CHW)) u_sel (
    .mask       (mask_q),
    .cur        (cur_ch),
    .from_start (state == ST_HDR),
    .found      (sel_found),
    .next       (sel_next)
  );

  logic [WORD_W-1:0] evid_word;
  logic [TID_W-1:0]  evid_low;
  logic [WORD_W-1:0] frame_word;

  assign evid_word = tm_q ? {{(WORD_W-TID_W){1'b0}}, tcnt} : evid_q;
  assign evid_low  = tm_q ? tcnt : evid_q[TID_W-1:0];

  frag_word_gen u_words (
    .in_trailer   (state == ST_TRL),
    .idx          (widx),
    .cfg_format   (cfg_format),
    .cfg_module   (cfg_module),
    .cfg_run      (cfg_run),
    .cfg_det_type (cfg_det_type),
    .evid_word    (evid_word),
    .evid_low     (evid_low),
    .bunch        (bid_q),
    .ttype        (tt_q),
    .total        (total),
    .flags        (err_flags),
    .word         (frame_word)
  );

  logic out_fire;
  assign out_fire = out_valid && out_ready;

  always_comb begin
    out_valid  = 1'b0;
    out_data   = '0;
    trig_ready = 1'b0;
    len_ready  = '0;
    dat_ready  = '0;
    case (state)
      ST_IDLE: trig_ready = 1'b1;
      ST_HDR, ST_TRL: begin
        out_valid = 1'b1;
        out_data  = frame_word;
      end
      ST_LEN: len_ready[cur_ch] = 1'b1;
      ST_DATA: begin
        out_valid         = dat_valid[cur_ch];
        out_data          = dat_arr[cur_ch];
        dat_ready[cur_ch] = out_ready;
      end
      ST_LINK: begin
        out_valid = 1'b1;
        out_data  = {K_LINK, 4'(cur_ch), cur_len};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      widx    <= '0;
      cur_ch  <= '0;
      rem     <= '0;
      cur_len <= '0;
      total   <= '0;
      mask_q  <= '0;
      tm_q    <= 1'b0;
      evid_q  <= '0;
      bid_q   <= '0;
      tt_q    <= '0;
      tcnt    <= '0;
    end else begin
      case (state)
        ST_IDLE: if (trig_valid) begin
          evid_q <= trig_event_id;
          bid_q  <= trig_bunch_id;
          tt_q   <= trig_type;
          mask_q <= chan_en;
          tm_q   <= test_mode;
          total  <= '0;
          widx   <= '0;
          state  <= ST_HDR;
        end
        ST_HDR: if (out_ready) begin
          if (widx == IDX_W'(HDR_LAST)) begin
            widx <= '0;
            if (sel_found) begin
              cur_ch <= sel_next;
              state  <= ST_LEN;
            end else begin
              state  <= ST_TRL;
            end
          end else begin
            widx <= widx + 1'b1;
          end
        end
        ST_LEN: if (len_valid[cur_ch]) begin
          cur_len <= len_arr[cur_ch];
          rem     <= len_arr[cur_ch];
          state   <= (len_arr[cur_ch] == '0) ? ST_LINK : ST_DATA;
        end
        ST_DATA: if (out_fire) begin
          total <= total + 1'b1;
          rem   <= rem - 1'b1;
          if (rem == LEN_W'(1)) state <= ST_LINK;
        end
        ST_LINK: if (out_ready) begin
          if (sel_found) begin
            cur_ch <= sel_next;
            state  <= ST_LEN;
          end else begin
            widx  <= '0;
            state <= ST_TRL;
          end
        end
        ST_TRL: if (out_ready) begin
          if (widx == IDX_W'(TRL_LAST)) begin
            tcnt  <= tcnt + 1'b1;
            state <= ST_IDLE;
          end else begin
            widx <= widx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R11
  AST_LEN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(len_ready)); // R5
  AST_DAT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dat_ready)); // R5
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((len_ready | dat_ready) & ~mask_q) == '0); // R4
  AST_TRIG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_ready |-> !out_valid); // R3
  AST_TCNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TRL && widx == IDX_W'(TRL_LAST) && out_ready)
      |=> (tcnt == $past(tcnt) + 1'b1)); // R10
endmodule

// File: tb/frag_builder_tb.sv
`timescale 1ns/1ps
module frag_builder_tb;
  localparam int NCH = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n;
  logic              test_mode;
  logic [NCH-1:0]    chan_en;
  logic [31:0]       cfg_format, cfg_module, cfg_run, cfg_det_type;
  logic [3:0]        err_flags;
  logic              trig_valid, trig_ready;
  logic [31:0]       trig_event_id;
  logic [11:0]       trig_bunch_id;
  logic [7:0]        trig_type;
  logic [NCH-1:0]    len_valid, len_ready, dat_valid, dat_ready;
  logic [NCH*16-1:0] len_data;
  logic [NCH*32-1:0] dat_word;
  logic              out_valid, out_ready;
  logic [31:0]       out_data;

  frag_builder #(.NCH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .chan_en(chan_en),
    .cfg_format(cfg_format), .cfg_module(cfg_module), .cfg_run(cfg_run),
    .cfg_det_type(cfg_det_type), .err_flags(err_flags),
    .trig_valid(trig_valid), .trig_ready(trig_ready),
    .trig_event_id(trig_event_id), .trig_bunch_id(trig_bunch_id),
    .trig_type(trig_type), .len_valid(len_valid), .len_ready(len_ready),
    .len_data(len_data), .dat_valid(dat_valid), .dat_ready(dat_ready),
    .dat_word(dat_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  logic [15:0] lq [NCH][$];
  logic [31:0] dq [NCH][$];
  logic [51:0] tq [$];
  logic [31:0] exp_q [$];
  string       exp_tag [$];

  int n_vec = 0;
  int n_bad = 0;
  int model_cnt = 0;
  bit rdy_rand = 0;
  bit hold_pend = 0;
  logic [31:0] hold_data;
  logic [NCH-1:0] cur_mask = '0;
  bit f_trig = 0, f_out = 0;
  logic [NCH-1:0] f_len = '0, f_dat = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // reference driver and monitor: sample 1 ns after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (f_trig) void'(tq.pop_front());
        for (int c = 0; c < NCH; c++) begin
          if (f_len[c]) void'(lq[c].pop_front());
          if (f_dat[c]) void'(dq[c].pop_front());
        end
      end
      trig_valid = (tq.size() > 0);
      {trig_event_id, trig_bunch_id, trig_type} = (tq.size() > 0) ? tq[0] : 52'h0;
      for (int c = 0; c < NCH; c++) begin
        len_valid[c] = (lq[c].size() > 0);
        len_data[c*16 +: 16] = (lq[c].size() > 0) ? lq[c][0] : 16'h0;
        dat_valid[c] = (dq[c].size() > 0);
        dat_word[c*32 +: 32] = (dq[c].size() > 0) ? dq[c][0] : 32'h0;
      end
      out_ready = rdy_rand ? (($urandom % 4) != 0) : 1'b1;
      #1;
      if (rst_n) begin
        f_trig = trig_valid && trig_ready;
        f_len  = len_valid & len_ready;
        f_dat  = dat_valid & dat_ready;
        f_out  = out_valid && out_ready;
        if (hold_pend) chk(out_valid && out_data == hold_data, "R11", out_data, hold_data);
        hold_pend = out_valid && !out_ready;
        hold_data = out_data;
        if (((len_ready | dat_ready) & ~cur_mask) != '0)
          chk(0, "R4", 32'(len_ready | dat_ready), 32'(cur_mask));
        if (f_out) begin
          if (exp_q.size() == 0) chk(0, "R3", out_data, 32'h0);
          else chk(out_data == exp_q[0], exp_tag[0], out_data, exp_q[0]);
          if (exp_q.size() > 0) begin
            void'(exp_q.pop_front());
            void'(exp_tag.pop_front());
          end
        end
      end else begin
        f_trig = 0; f_out = 0; f_len = '0; f_dat = '0; hold_pend = 0;
      end
    end
  end

  task automatic push(input logic [31:0] w, input string tag);
    exp_q.push_back(w);
    exp_tag.push_back(tag);
  endtask

  task automatic run_frag(input logic [NCH-1:0] mask, input bit tm, input logic [3:0] fl,
                          input int lens[NCH], input int delay, input bit rr);
    logic [31:0] evid, ew, w;
    logic [11:0] bid;
    logic [7:0]  tt;
    logic [15:0] tot;
    logic [31:0] words [NCH][$];
    int guard;
    evid = $urandom; bid = 12'($urandom); tt = 8'($urandom); tot = 0;
    chan_en = mask; test_mode = tm; err_flags = fl; rdy_rand = rr; cur_mask = mask;
    ew = tm ? {8'h00, 24'(model_cnt)} : evid;
    push(32'hB0F00000, "R1"); push(32'hEE1234EE, "R1"); push(32'h9, "R1");
    push(cfg_format, "R1"); push(cfg_module, "R1"); push(cfg_run, "R1");
    push(ew, "R9"); push({20'h0, bid}, "R1"); push({24'h0, tt}, "R1");
    push(cfg_det_type, "R1"); push({8'h80, ew[23:0]}, tm ? "R10" : "R9");
    for (int c = 0; c < NCH; c++) begin
      if (mask[c]) begin
        for (int k = 0; k < lens[c]; k++) begin
          w = $urandom;
          words[c].push_back(w);
          push(w, "R5");
          tot++;
        end
        push({12'hC00, 4'(c), 16'(lens[c])}, (lens[c] == 0) ? "R6" : "R5");
      end
    end
    push({16'hF000, tot}, (mask == 0) ? "R13" : "R7");
    push({28'h0, fl}, "R8"); push(32'h1, "R2");
    push({16'h0, tot}, "R7"); push(32'h1, "R2"); push(32'hE0F00000, "R2");
    if (delay < 0) begin
      for (int c = 0; c < NCH; c++) if (mask[c]) begin
        lq[c].push_back(16'(lens[c]));
        foreach (words[c][k]) dq[c].push_back(words[c][k]);
      end
      for (int i = 0; i < -delay; i++) begin
        @(negedge clk); #1;
        chk(!out_valid && len_ready == '0 && dat_ready == '0, "R3", {31'h0, out_valid}, 32'h0);
      end
      tq.push_back({evid, bid, tt});
    end else begin
      tq.push_back({evid, bid, tt});
      repeat (delay) @(negedge clk);
      for (int c = 0; c < NCH; c++) if (mask[c]) begin
        lq[c].push_back(16'(lens[c]));
        foreach (words[c][k]) dq[c].push_back(words[c][k]);
      end
    end
    guard = 0;
    while (exp_q.size() > 0 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    if (guard >= 5000) begin
      chk(0, "watchdog", 32'(exp_q.size()), 32'h0);
      exp_q.delete();
      exp_tag.delete();
    end
    repeat (3) @(negedge clk);
    model_cnt++;
  endtask

  initial begin
    rst_n = 0; test_mode = 0; chan_en = '0; err_flags = '0;
    cfg_format = 32'h03000000; cfg_module = 32'h00610080;
    cfg_run = 32'h00001234; cfg_det_type = 32'h0000000A;
    trig_valid = 0; trig_event_id = 0; trig_bunch_id = 0; trig_type = 0;
    len_valid = '0; len_data = '0; dat_valid = '0; dat_word = '0; out_ready = 1;
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid && len_ready == '0 && dat_ready == '0, "R12", {31'h0, out_valid}, 32'h0);
    @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    #1;
    chk(trig_ready && !out_valid, "R12", {31'h0, trig_ready}, 32'h1);

    run_frag(8'hFF, 0, 4'h0, '{3,1,4,2,5,1,2,6}, 0, 0);
    lq[1].push_back(16'd2); dq[1].push_back(32'h11111111); dq[1].push_back(32'h22222222);
    run_frag(8'hA5, 0, 4'h5, '{2,7,0,3,1,4,2,2}, 0, 1);
    chk(lq[1].size() == 1 && dq[1].size() == 2, "R4", 32'(dq[1].size()), 32'd2);
    lq[1].delete(); dq[1].delete();
    run_frag(8'h00, 0, 4'hF, '{1,1,1,1,1,1,1,1}, 0, 1);
    run_frag(8'h3C, 0, 4'h2, '{0,0,0,5,0,3,0,0}, 0, 1);
    run_frag(8'h81, 0, 4'h8, '{4,0,0,0,0,0,0,3}, -15, 1);
    run_frag(8'h12, 1, 4'hA, '{0,3,0,0,2,0,0,0}, 0, 1);
    run_frag(8'hFF, 1, 4'h1, '{1,2,3,0,1,2,3,1}, 10, 1);
    run_frag(8'h40, 0, 4'h4, '{0,0,0,0,0,0,9,0}, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule